// File: doc/BRIEF.md
# Eight-Channel Shared-Counter Match Timer

This block provides eight match timer channels, numbered 4 to 11 in the interrupt status space and 0 to 7 inside the bank. Every channel holds a 32-bit match value, a control word and a counter of its own. By default a channel compares against a counter that belongs to another channel, chosen by a fixed ownership table. A control bit makes the channel compare against its own counter instead. Each counter advances on a tick-enable input that its owning channel selects from eight external sources.

The control word sets the tick source, whether the compared counter clears on a match, and whether the channel matches again on later passes or only once. On the two odd channels of the upper half it can also enable a snapshot, which copies the neighbouring counter when the channel's counter is read. A match sets that channel's status bit if its enable bit is set. The eight status bits OR into a single interrupt line. Software clears status bits by writing ones to them.

Software reaches the block through a flat register select. `addr_i[4:3]` selects the register kind: 0 is match, 1 is counter, 2 is control and 3 is miscellaneous. `addr_i[2:0]` selects the channel. The miscellaneous kind holds interrupt enable at channel 0, status at channel 1 and the snapshot at channel 2. Enable and status place bank channel k at data bit k+4. Reads return data combinationally. Writes take effect at the clock edge.

Top module: `match_timer_bank`

## Requirements
- R1: With control bit 7 clear, channel k compares against the counter of channel 0,0,0,0,4,4,6,6 for k = 0..7. With bit 7 set, it compares against counter k. A counter read at channel k always returns counter k.
- R2: Counter k advances by one on each clock edge at which tick input `tick_i[s]` is high, where s is channel k's latched source. The latched source resets to 0. When the tick input is low, the counter holds.
- R3: A control write keeps data bits 7:0 on channels 0..3 and bits 9:0 on channels 4..7. Reads return the kept value.
- R4: A control write updates the latched source from data bits 2:0 only in two cases: on channels 0..3 when bit 7 is set or the channel is 0, and on channels 4..7 when bit 7 is set or the channel is even. On channels 4..7, bit 8 forces source 0.
- R5: A match occurs when an armed channel's compared counter advances to the match value. With control bit 3 set, a match clears the compared counter to 0 instead of advancing it.
- R6: With control bit 6 set, a channel stays armed after a match. Otherwise it disarms. A write to its match register or to its compared counter re-arms it.
- R7: Reading the counter of channel 5 or 7 while that channel's control bit 9 is set copies the counter of channel 4 or 6, respectively, into the snapshot register. Other reads leave the snapshot unchanged.
- R8: A match sets status bit k+4 only if enable bit k+4 is set.
- R9: `irq_o` is high whenever any status bit is set. A status write clears the bits written as 1. A match in the same cycle wins over the clear.
- R10: A counter write loads the value at that edge and suppresses advancing in that cycle. Every channel sharing that counter compares the new value from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 8 | Tick-enable sources 0..7 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers snapshot capture) |
| addr_i | input | 5 | {kind[1:0], channel[2:0]} register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Combined match interrupt |

## Verification
A wrong latched source or a wrong ownership choice shows up as a counter that moves on the wrong tick input, or as a match on the wrong channel. Both are visible in the counter read or the status word one cycle after the tick. A wrongly kept armed flag shows up as a missing or extra status bit on the next pass through the match value. A bad clear-on-match shows up at once as a non-zero counter read after the match. Snapshot and status corruption appear on the very next read of those registers.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int NCH = 8;
  localparam int CW  = 10;
  localparam int CHW = 3;

  localparam int CB_RST    = 3;
  localparam int CB_PER    = 6;
  localparam int CB_OWN    = 7;
  localparam int CB_FORCE0 = 8;
  localparam int CB_SNAP   = 9;

  typedef enum logic [1:0] {
    K_MATCH = 2'd0,
    K_COUNT = 2'd1,
    K_CTRL  = 2'd2,
    K_MISC  = 2'd3
  } kind_e;

  localparam logic [CHW-1:0] MISC_IE   = 3'd0;
  localparam logic [CHW-1:0] MISC_STAT = 3'd1;
  localparam logic [CHW-1:0] MISC_SNAP = 3'd2;

  function automatic logic [CHW-1:0] share_owner(input logic [CHW-1:0] ch);
    case (ch)
      3'd4, 3'd5: share_owner = 3'd4;
      3'd6, 3'd7: share_owner = 3'd6;
      default:    share_owner = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/tmb_counter.sv
module tmb_counter #(
  parameter int DW   = 32,
  parameter int NSRC = 8,
  parameter int SW   = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] tick_i,
  input  logic [SW-1:0]   src_i,
  input  logic            ld_i,
  input  logic [DW-1:0]   ld_val_i,
  input  logic            clr_i,
  output logic [DW-1:0]   cnt_o,
  output logic [DW-1:0]   nxt_o,
  output logic            adv_o
);
  logic [DW-1:0] cnt_q;

  assign adv_o = tick_i[src_i] && !ld_i;
  assign nxt_o = cnt_q + DW'(1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (adv_o)  cnt_q <= clr_i ? '0 : nxt_o;
  end

  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_o == $past(ld_val_i));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && tick_i[src_i] && !ld_i) |=> cnt_o == '0);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !tick_i[src_i]) |=> $stable(cnt_o));
endmodule

// File: rtl/tmb_channel.sv
module tmb_channel
  import tmb_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 3,
  parameter int CH = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          match_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rearm_i,
  input  logic          adv_i,
  input  logic [DW-1:0] nxt_i,
  output logic          hit_o,
  output logic [CW-1:0] ctl_o,
  output logic [SW-1:0] src_o,
  output logic [DW-1:0] match_o
);
  localparam bit UPPER = (CH >= 4);
  localparam logic [CW-1:0] CMASK = UPPER ? CW'(10'h3ff) : CW'(10'h0ff);

  logic [CW-1:0] ctl_q;
  logic [SW-1:0] src_q;
  logic [DW-1:0] match_q;
  logic          armed_q;
  logic          src_upd;
  logic [SW-1:0] src_new;

  always_comb begin
    src_new = wdata_i[SW-1:0];
    if (UPPER) begin
      src_upd = wdata_i[CB_OWN] || (CH % 2 == 0);
      if (wdata_i[CB_FORCE0]) src_new = '0;
    end else begin
      src_upd = wdata_i[CB_OWN] || (CH == 0);
    end
  end

  assign hit_o   = armed_q && adv_i && (nxt_i == match_q);
  assign ctl_o   = ctl_q;
  assign src_o   = src_q;
  assign match_o = match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      src_q   <= '0;
      match_q <= '0;
      armed_q <= 1'b1;
    end else begin
      if (ctl_we_i) begin
        ctl_q <= wdata_i[CW-1:0] & CMASK;
        if (src_upd) src_q <= src_new;
      end
      if (match_we_i) match_q <= wdata_i;
      if (match_we_i || rearm_i)        armed_q <= 1'b1;
      else if (hit_o && !ctl_q[CB_PER]) armed_q <= 1'b0;
    end
  end

  a_r6_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !ctl_q[CB_PER] && !match_we_i && !rearm_i) |=> !armed_q);
  a_r6_periodic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && ctl_q[CB_PER]) |=> armed_q);
  a_r4_src_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !wdata_i[CB_OWN] && (CH != 0) && (!UPPER || (CH % 2 == 1)))
      |=> $stable(src_q));
endmodule

// File: rtl/match_timer_bank.sv
module match_timer_bank
  import tmb_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSRC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] tick_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [4:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  localparam int SW   = $clog2(NSRC);
  localparam int SOFF = 4;

  kind_e          kind;
  logic [CHW-1:0] ch;
  assign kind = kind_e'(addr_i[4:3]);
  assign ch   = addr_i[2:0];

  logic [NCH-1:0][DW-1:0]  cnt_w, nxt_w, match_w;
  logic [NCH-1:0]          adv_w, ld_w, clr_w, hit_w, ctl_we, match_we;
  logic [NCH-1:0][CW-1:0]  ctl_w;
  logic [NCH-1:0][SW-1:0]  src_w;
  logic [NCH-1:0][CHW-1:0] sel_w;
  logic [NCH-1:0]          ie_q, st_q, st_clr;
  logic [DW-1:0]           snap_q;
  logic                    snap_cap;
  logic                    st_wr;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      sel_w[k]    = ctl_w[k][CB_OWN] ? CHW'(k) : share_owner(CHW'(k));
      ld_w[k]     = wr_en_i && (kind == K_COUNT) && (ch == CHW'(k));
      ctl_we[k]   = wr_en_i && (kind == K_CTRL)  && (ch == CHW'(k));
      match_we[k] = wr_en_i && (kind == K_MATCH) && (ch == CHW'(k));
    end
    for (int c = 0; c < NCH; c++) begin
      clr_w[c] = 1'b0;
      for (int k = 0; k < NCH; k++)
        if (hit_w[k] && ctl_w[k][CB_RST] && (sel_w[k] == CHW'(c))) clr_w[c] = 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cnt
    tmb_counter #(.DW(DW), .NSRC(NSRC), .SW(SW)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .src_i    (src_w[g]),
      .ld_i     (ld_w[g]),
      .ld_val_i (wdata_i),
      .clr_i    (clr_w[g]),
      .cnt_o    (cnt_w[g]),
      .nxt_o    (nxt_w[g]),
      .adv_o    (adv_w[g])
    );
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmb_channel #(.DW(DW), .SW(SW), .CH(g)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_we_i   (ctl_we[g]),
      .match_we_i (match_we[g]),
      .wdata_i    (wdata_i),
      .rearm_i    (ld_w[sel_w[g]]),
      .adv_i      (adv_w[sel_w[g]]),
      .nxt_i      (nxt_w[sel_w[g]]),
      .hit_o      (hit_w[g]),
      .ctl_o      (ctl_w[g]),
      .src_o      (src_w[g]),
      .match_o    (match_w[g])
    );
  end

  // status, enable, snapshot
  assign st_wr    = wr_en_i && (kind == K_MISC) && (ch == MISC_STAT);
  assign st_clr   = st_wr ? wdata_i[SOFF +: NCH] : '0;
  assign snap_cap = rd_en_i && (kind == K_COUNT) && ch[0] && ch[2] &&
                    ctl_w[ch][CB_SNAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= '0;
      st_q   <= '0;
      snap_q <= '0;
    end else begin
      if (wr_en_i && (kind == K_MISC) && (ch == MISC_IE)) ie_q <= wdata_i[SOFF +: NCH];
      st_q <= (st_q & ~st_clr) | (hit_w & ie_q);
      if (snap_cap) snap_q <= cnt_w[ch - CHW'(1)];
    end
  end

  assign irq_o = |st_q;

  always_comb begin
    rdata_o = '0;
    unique case (kind)
      K_MATCH: rdata_o = match_w[ch];
      K_COUNT: rdata_o = cnt_w[ch];
      K_CTRL:  rdata_o = DW'(ctl_w[ch]);
      K_MISC: begin
        if (ch == MISC_IE)        rdata_o[SOFF +: NCH] = ie_q;
        else if (ch == MISC_STAT) rdata_o[SOFF +: NCH] = st_q;
        else if (ch == MISC_SNAP) rdata_o = snap_q;
      end
      default: rdata_o = '0;
    endcase
  end

  a_r9_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !st_wr) |=> irq_o);
  a_r8_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == '0) && ((hit_w & ie_q) == '0)) |=> (st_q == '0));
  a_r7_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_cap |=> $stable(snap_q));
endmodule

// File: tb/match_timer_bank_tb.sv
module match_timer_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] KM = 2'd0, KC = 2'd1, KT = 2'd2, KX = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tick = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h exp 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] c, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = {k, c}; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] k, input logic [2:0] c, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = {k, c};
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tk(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick[s] = 1'b1;
      @(negedge clk); tick = '0;
    end
  endtask

  task automatic t_reset;
    rd(KC, 0, v); chk("R2 reset counter", v, 0);
    rd(KX, 1, v); chk("R9 reset status", v, 0);
    chk("R9 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_basic;
    wr(KX, 0, 32'h0ff0);
    wr(KC, 0, 0);
    wr(KM, 0, 5);
    tk(0, 4);
    rd(KX, 1, v); chk("R8 no early match", v, 0);
    tk(0, 1);
    rd(KX, 1, v); chk("R2 match after 5 ticks", v, 32'h010);
    chk("R9 irq set", {31'd0, irq}, 1);
    wr(KX, 1, 32'h010);
    chk("R9 irq cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_enable_gate;
    wr(KX, 0, 32'h020);
    wr(KM, 0, 7);
    tk(0, 2);
    rd(KX, 1, v); chk("R8 disabled channel no status", v, 0);
    chk("R8 irq low", {31'd0, irq}, 0);
    wr(KX, 0, 32'h0ff0);
  endtask

  task automatic t_shared;
    wr(KM, 3, 100);
    wr(KC, 0, 99);
    tk(0, 1);
    rd(KX, 1, v); chk("R1 R10 shared counter match ch3", v, 32'h080);
    wr(KX, 1, 32'h080);
  endtask

  task automatic t_reset_on_match;
    wr(KT, 2, 32'h48);
    wr(KM, 2, 3);
    wr(KC, 0, 0);
    tk(0, 3);
    rd(KC, 0, v); chk("R5 counter cleared on match", v, 0);
    rd(KX, 1, v); chk("R5 status ch2", v, 32'h040);
    wr(KX, 1, 32'h040);
    tk(0, 3);
    rd(KX, 1, v); chk("R6 periodic second match", v, 32'h040);
    wr(KX, 1, 32'h040);
    wr(KT, 2, 32'h08);
    wr(KC, 0, 0);
    tk(0, 3);
    rd(KX, 1, v); chk("R6 one-shot first match", v, 32'h040);
    wr(KX, 1, 32'h040);
    tk(0, 3);
    rd(KX, 1, v); chk("R6 one-shot no second match", v, 0);
    rd(KC, 0, v); chk("R5 disarmed does not clear", v, 3);
    wr(KT, 2, 0);
  endtask

  task automatic t_own_counter;
    wr(KT, 1, 32'h83);
    wr(KM, 1, 2);
    wr(KC, 1, 0);
    tk(0, 2);
    rd(KC, 1, v); chk("R2 own counter ignores src0", v, 0);
    rd(KX, 1, v); chk("R1 no match on shared counter", v, 0);
    tk(3, 2);
    rd(KC, 1, v); chk("R2 own counter on src3", v, 2);
    rd(KX, 1, v); chk("R1 own counter match", v, 32'h020);
    wr(KX, 1, 32'h020);
  endtask

  task automatic t_rate_rules;
    wr(KT, 5, 32'h002);
    wr(KC, 5, 0);
    tk(2, 1);
    rd(KC, 5, v); chk("R4 odd upper keeps src", v, 0);
    tk(0, 1);
    rd(KC, 5, v); chk("R4 odd upper still src0", v, 1);
    wr(KT, 4, 32'h002);
    wr(KC, 4, 0);
    tk(2, 1);
    rd(KC, 4, v); chk("R4 even upper takes src2", v, 1);
    wr(KT, 4, 32'h102);
    tk(2, 1);
    rd(KC, 4, v); chk("R4 force0 ignores src2", v, 1);
    tk(0, 1);
    rd(KC, 4, v); chk("R4 force0 uses src0", v, 2);
    wr(KT, 4, 0);
    wr(KT, 2, 32'h03);
    wr(KC, 2, 0);
    tk(3, 1);
    rd(KC, 2, v); chk("R4 lower ch2 keeps src", v, 0);
    tk(0, 1);
    rd(KC, 2, v); chk("R4 lower ch2 src0", v, 1);
    wr(KT, 2, 0);
    wr(KT, 3, 32'hfff);
    rd(KT, 3, v); chk("R3 lower mask", v, 32'h0ff);
    wr(KT, 3, 0);
    wr(KT, 6, 32'hfff);
    rd(KT, 6, v); chk("R3 upper mask", v, 32'h3ff);
    wr(KT, 6, 0);
  endtask

  task automatic t_snapshot;
    wr(KT, 5, 32'h200);
    wr(KC, 4, 32'h1234);
    rd(KC, 5, v);
    rd(KX, 2, v); chk("R7 snapshot of ch4", v, 32'h1234);
    wr(KC, 4, 32'h55);
    wr(KT, 7, 0);
    rd(KC, 7, v);
    rd(KX, 2, v); chk("R7 ch7 without enable no capture", v, 32'h1234);
    wr(KT, 5, 0);
    rd(KC, 5, v);
    rd(KX, 2, v); chk("R7 ch5 disabled no capture", v, 32'h1234);
  endtask

  task automatic t_w1c;
    wr(KM, 0, 10);
    wr(KM, 3, 11);
    wr(KC, 0, 8);
    tk(0, 3);
    rd(KX, 1, v); chk("R9 two status bits", v, 32'h090);
    wr(KX, 1, 32'h010);
    rd(KX, 1, v); chk("R9 partial clear", v, 32'h080);
    chk("R9 irq stays with bit left", {31'd0, irq}, 1);
    wr(KX, 1, 32'h080);
    chk("R9 irq drops when empty", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_enable_gate();
    t_shared();
    t_reset_on_match();
    t_own_counter();
    t_rate_rules();
    t_snapshot();
    t_w1c();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule